// File: doc/BRIEF.md
# Delayed Read Completion Buffer

This block sits between a simplified bus target port and a slow local bus. A requester presents a read or write and holds `req_valid` until the block answers with a one-cycle `rsp_done` or `rsp_retry` pulse. It then drops `req_valid` for at least one cycle. If the local bus returns read data inside the initial latency window, the read completes at once.

If the data does not arrive in time, the attempt ends with a retry. The block records who asked and for what address, and lets the local read finish in the background. It keeps the returned word until that same requester repeats the same read.

While such a deferred read is outstanding, every other read is turned away with a retry. No second local read is started. The held word therefore cannot be overwritten by another requester. Addresses with the top address bit set are prefetchable. A held word for such an address is dropped if nobody claims it within a set time. The next fetch of an address that was just dropped is pinned, so that a slow location cannot be fetched and dropped over and over. Writes are posted to the local bus. A write that targets the address of the outstanding read is retried, which keeps the read and the write in order.

Top module: `dlyrd_buf`

## Requirements
- R1: After reset, `rsp_done`, `rsp_retry` and `lb_req` are low.
- R2: A read whose local-bus acknowledge comes inside the latency window completes with `rsp_done`, and `rsp_rdata` equals the local-bus data. No retry is given for it, and the two response pulses are never high together.
- R3: A read whose data does not arrive inside the window gets `rsp_retry` no more than LAT_CYCLES clock cycles after `req_valid` is raised. The local read keeps running.
- R4: A repeated read with the same requester ID and the same address, made after the late data has arrived, completes with that data. The local bus is read only once for it.
- R5: A repeated matching read made before the late data has arrived gets `rsp_retry` again.
- R6: While a deferred read is outstanding, a read with a different requester ID or a different address gets `rsp_retry`. No local-bus read is started for it, and the held entry is kept.
- R7: A held word for a non-prefetchable address (address bit AW-1 clear) is never dropped, however long it waits.
- R8: A held word for a prefetchable address (address bit AW-1 set) is dropped after DISCARD_CYCLES cycles without a matching read. After that, new reads are served normally.
- R9: A deferred read of the prefetchable address that was dropped most recently is pinned. Its held word is not dropped by the timer and is delivered when the requester returns.
- R10: A write to the address of an outstanding deferred read is retried, and so is any write while the local bus is busy. Any other write is acknowledged with `rsp_done` and performed once on the local bus with its data.
- R11: The local bus carries one operation at a time. `lb_req` stays high with a stable address and direction until `lb_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until a response pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | ID_W | Requester identity |
| req_addr | input | AW | Request address; bit AW-1 set marks it prefetchable |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle pulse: request completed |
| rsp_retry | output | 1 | One-cycle pulse: request refused, try again |
| rsp_rdata | output | DW | Read data, valid with `rsp_done` for reads |
| lb_req | output | 1 | Local-bus operation request |
| lb_we | output | 1 | Local-bus direction, 1 = write |
| lb_addr | output | AW | Local-bus address |
| lb_wdata | output | DW | Local-bus write data |
| lb_ack | input | 1 | Local-bus completion pulse |
| lb_rdata | input | DW | Local-bus read data, valid with `lb_ack` |

## Verification
A fast local bus gives immediate completion. A slow one separates the deferred path from the direct one. Repeated reads are then made by the owner, by a different requester and to a different address. Each is checked against the bench's count of local reads per address, because the returned word encodes how many times that address was read. This shows whether a location was read twice or was handed to the wrong requester. Long idle waits on a non-prefetchable address, a prefetchable address and a pinned prefetchable address test the three holding policies against one another. Writes to the held address, writes during a busy local bus and writes elsewhere test the ordering rule.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_GAP
    } tgt_state_e;

    typedef enum logic [2:0] {
        ACT_WAIT,
        ACT_WR_POST,
        ACT_RETRY,
        ACT_HIT,
        ACT_RD_START,
        ACT_RD_DONE,
        ACT_RD_DEFER
    } tgt_act_e;

    function automatic logic act_refuses(tgt_act_e a);
        return (a == ACT_RETRY) || (a == ACT_RD_DEFER);
    endfunction

    function automatic logic act_finishes(tgt_act_e a);
        return (a == ACT_WR_POST) || (a == ACT_HIT) || (a == ACT_RD_DONE);
    endfunction

    function automatic logic act_uses_bus(tgt_act_e a);
        return (a == ACT_WR_POST) || (a == ACT_RD_START);
    endfunction

endpackage

// File: rtl/dlyrd_lbus.sv
module dlyrd_lbus #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          busy,
    output logic          rd_ack,
    output logic [DW-1:0] rd_data,
    output logic          lb_req,
    output logic          lb_we,
    output logic [AW-1:0] lb_addr,
    output logic [DW-1:0] lb_wdata,
    input  logic          lb_ack,
    input  logic [DW-1:0] lb_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_req   <= 1'b0;
            lb_we    <= 1'b0;
            lb_addr  <= '0;
            lb_wdata <= '0;
        end else if (start) begin
            lb_req   <= 1'b1;
            lb_we    <= start_we;
            lb_addr  <= start_addr;
            lb_wdata <= start_wdata;
        end else if (lb_ack) begin
            lb_req   <= 1'b0;
        end
    end

    assign busy    = lb_req;
    assign rd_ack  = lb_ack && lb_req && !lb_we;
    assign rd_data = lb_rdata;

    // R11: one operation at a time
    assert_one_op_R11: assert property (@(posedge clk) disable iff (rst)
        start |-> !lb_req);

    // R11: request and its fields held until acknowledged
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (lb_req && !lb_ack) |=> (lb_req && $stable(lb_addr) && $stable(lb_we)));

endmodule

// File: rtl/dlyrd_entry.sv
module dlyrd_entry #(
    parameter int ID_W           = 3,
    parameter int AW             = 16,
    parameter int DW             = 32,
    parameter int DISCARD_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  logic [ID_W-1:0] alloc_id,
    input  logic [AW-1:0]   alloc_addr,
    input  logic            fill,
    input  logic [DW-1:0]   fill_data,
    input  logic            take,
    output logic            valid,
    output logic            have,
    output logic [ID_W-1:0] id,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   data
);

    localparam int TW     = (DISCARD_CYCLES > 1) ? $clog2(DISCARD_CYCLES) : 1;
    localparam int PF_BIT = AW - 1;

    logic          pf;
    logic          pinned;
    logic [TW-1:0] age;
    logic          drop_valid;
    logic [AW-1:0] drop_addr;
    logic          aging;
    logic          discard;

    assign aging   = valid && have && pf && !pinned;
    assign discard = aging && !take && (age == TW'(DISCARD_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid      <= 1'b0;
            have       <= 1'b0;
            id         <= '0;
            addr       <= '0;
            data       <= '0;
            pf         <= 1'b0;
            pinned     <= 1'b0;
            age        <= '0;
            drop_valid <= 1'b0;
            drop_addr  <= '0;
        end else begin
            if (alloc) begin
                valid  <= 1'b1;
                have   <= 1'b0;
                id     <= alloc_id;
                addr   <= alloc_addr;
                pf     <= alloc_addr[PF_BIT];
                pinned <= alloc_addr[PF_BIT] && drop_valid && (drop_addr == alloc_addr);
                age    <= '0;
            end else if (take) begin
                valid <= 1'b0;
                have  <= 1'b0;
                if (pinned) drop_valid <= 1'b0;
            end else if (discard) begin
                valid      <= 1'b0;
                have       <= 1'b0;
                drop_valid <= 1'b1;
                drop_addr  <= addr;
            end else begin
                if (fill && valid && !have) begin
                    have <= 1'b1;
                    data <= fill_data;
                end
                if (aging) age <= age + 1'b1;
            end
        end
    end

    // R7: side-effecting reads are never dropped
    assert_keep_np_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !pf && !take) |=> valid);

    // R9: a pinned entry survives until claimed
    assert_keep_pinned_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && pinned && !take) |=> valid);

    // R6: a new deferred read never replaces a live entry
    assert_alloc_free_R6: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !valid);

    // R8: an entry only disappears when claimed or when a prefetchable word times out
    assert_drop_pf_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && !take && !(have && pf)) |=> valid);

endmodule

// File: rtl/dlyrd_ctrl.sv
module dlyrd_ctrl
    import dlyrd_pkg::*;
#(
    parameter int ID_W       = 3,
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LAT_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [ID_W-1:0] req_id,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_done,
    output logic            rsp_retry,
    output logic [DW-1:0]   rsp_rdata,
    input  logic            ent_valid,
    input  logic            ent_have,
    input  logic [ID_W-1:0] ent_id,
    input  logic [AW-1:0]   ent_addr,
    input  logic [DW-1:0]   ent_data,
    output logic            ent_alloc,
    output logic            ent_take,
    output logic [ID_W-1:0] alloc_id,
    output logic [AW-1:0]   alloc_addr,
    input  logic            lb_busy,
    input  logic            lb_rd_ack,
    input  logic [DW-1:0]   lb_rd_data,
    output logic            lb_start,
    output logic            lb_start_we,
    output logic [AW-1:0]   lb_start_addr,
    output logic [DW-1:0]   lb_start_wdata
);

    localparam int CW = $clog2(LAT_CYCLES);

    tgt_state_e      st;
    tgt_act_e        act;
    logic [CW-1:0]   wait_cnt;
    logic [ID_W-1:0] cur_id;
    logic [AW-1:0]   cur_addr;
    logic            owner_hit;
    logic            addr_clash;

    assign owner_hit  = ent_valid && (ent_id == req_id) && (ent_addr == req_addr);
    assign addr_clash = ent_valid && (ent_addr == req_addr);

    always_comb begin
        act = ACT_WAIT;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write)
                        act = (addr_clash || lb_busy) ? ACT_RETRY : ACT_WR_POST;
                    else if (ent_valid)
                        act = (owner_hit && ent_have) ? ACT_HIT : ACT_RETRY;
                    else if (lb_busy)
                        act = ACT_RETRY;
                    else
                        act = ACT_RD_START;
                end
            end
            ST_FETCH: begin
                if (lb_rd_ack)
                    act = ACT_RD_DONE;
                else if (wait_cnt == CW'(LAT_CYCLES - 2))
                    act = ACT_RD_DEFER;
            end
            default: act = ACT_WAIT;
        endcase
    end

    assign lb_start       = act_uses_bus(act);
    assign lb_start_we    = req_write;
    assign lb_start_addr  = req_addr;
    assign lb_start_wdata = req_wdata;
    assign ent_take       = (act == ACT_HIT);
    assign ent_alloc      = (act == ACT_RD_DEFER);
    assign alloc_id       = cur_id;
    assign alloc_addr     = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            wait_cnt  <= '0;
            cur_id    <= '0;
            cur_addr  <= '0;
            rsp_done  <= 1'b0;
            rsp_retry <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done  <= act_finishes(act);
            rsp_retry <= act_refuses(act);
            if (act == ACT_HIT)
                rsp_rdata <= ent_data;
            else if (act == ACT_RD_DONE)
                rsp_rdata <= lb_rd_data;
            unique case (st)
                ST_IDLE: begin
                    if (act == ACT_RD_START) begin
                        st       <= ST_FETCH;
                        wait_cnt <= '0;
                        cur_id   <= req_id;
                        cur_addr <= req_addr;
                    end else if (act != ACT_WAIT) begin
                        st <= ST_GAP;
                    end
                end
                ST_FETCH: begin
                    if (act != ACT_WAIT) st <= ST_GAP;
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                default: begin
                    if (!req_valid) st <= ST_IDLE;
                end
            endcase
        end
    end

    // R2: one response kind at a time
    assert_one_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_done, rsp_retry}));

    // R6: no second local read while an entry is outstanding
    assert_no_second_read_R6: assert property (@(posedge clk) disable iff (rst)
        (lb_start && !lb_start_we) |-> !ent_valid);

    // R10: a write never overtakes the deferred read of the same address
    assert_wr_order_R10: assert property (@(posedge clk) disable iff (rst)
        (lb_start && lb_start_we) |-> !(ent_valid && (ent_addr == lb_start_addr)));

    // R3: a fetch never outlives the latency window
    assert_window_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH && !lb_rd_ack && wait_cnt == CW'(LAT_CYCLES - 2)) |=> rsp_retry);

endmodule

// File: rtl/dlyrd_buf.sv
module dlyrd_buf #(
    parameter int ID_W           = 3,
    parameter int AW             = 16,
    parameter int DW             = 32,
    parameter int LAT_CYCLES     = 16,
    parameter int DISCARD_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [ID_W-1:0] req_id,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_done,
    output logic            rsp_retry,
    output logic [DW-1:0]   rsp_rdata,
    output logic            lb_req,
    output logic            lb_we,
    output logic [AW-1:0]   lb_addr,
    output logic [DW-1:0]   lb_wdata,
    input  logic            lb_ack,
    input  logic [DW-1:0]   lb_rdata
);

    logic            ent_valid, ent_have, ent_alloc, ent_take;
    logic [ID_W-1:0] ent_id, alloc_id;
    logic [AW-1:0]   ent_addr, alloc_addr;
    logic [DW-1:0]   ent_data;
    logic            lb_busy, lb_rd_ack;
    logic [DW-1:0]   lb_rd_data;
    logic            lb_start, lb_start_we;
    logic [AW-1:0]   lb_start_addr;
    logic [DW-1:0]   lb_start_wdata;

    dlyrd_ctrl #(.ID_W(ID_W), .AW(AW), .DW(DW), .LAT_CYCLES(LAT_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_id(req_id),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .ent_valid(ent_valid), .ent_have(ent_have), .ent_id(ent_id),
        .ent_addr(ent_addr), .ent_data(ent_data),
        .ent_alloc(ent_alloc), .ent_take(ent_take),
        .alloc_id(alloc_id), .alloc_addr(alloc_addr),
        .lb_busy(lb_busy), .lb_rd_ack(lb_rd_ack), .lb_rd_data(lb_rd_data),
        .lb_start(lb_start), .lb_start_we(lb_start_we),
        .lb_start_addr(lb_start_addr), .lb_start_wdata(lb_start_wdata)
    );

    dlyrd_entry #(.ID_W(ID_W), .AW(AW), .DW(DW), .DISCARD_CYCLES(DISCARD_CYCLES)) u_entry (
        .clk(clk), .rst(rst),
        .alloc(ent_alloc), .alloc_id(alloc_id), .alloc_addr(alloc_addr),
        .fill(lb_rd_ack), .fill_data(lb_rd_data), .take(ent_take),
        .valid(ent_valid), .have(ent_have), .id(ent_id),
        .addr(ent_addr), .data(ent_data)
    );

    dlyrd_lbus #(.AW(AW), .DW(DW)) u_lbus (
        .clk(clk), .rst(rst),
        .start(lb_start), .start_we(lb_start_we),
        .start_addr(lb_start_addr), .start_wdata(lb_start_wdata),
        .busy(lb_busy), .rd_ack(lb_rd_ack), .rd_data(lb_rd_data),
        .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
        .lb_ack(lb_ack), .lb_rdata(lb_rdata)
    );

endmodule

// File: tb/test_dlyrd_buf.sv
`timescale 1ns/1ps
module test_dlyrd_buf;

    localparam int ID_W = 3;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int LAT  = 16;
    localparam int DISC = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst = 1'b1;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            rsp_done, rsp_retry;
    logic [DW-1:0]   rsp_rdata;
    logic            lb_req, lb_we;
    logic [AW-1:0]   lb_addr;
    logic [DW-1:0]   lb_wdata;
    logic            lb_ack = 1'b0;
    logic [DW-1:0]   lb_rdata = '0;

    dlyrd_buf #(.ID_W(ID_W), .AW(AW), .DW(DW), .LAT_CYCLES(LAT), .DISCARD_CYCLES(DISC)) i_dlyrd_buf (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
        .lb_ack(lb_ack), .lb_rdata(lb_rdata)
    );

    int n_checks = 0, n_fail = 0, n_rsp = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input int n, input logic [15:0] a);
        return {n[7:0], 8'h00, a};
    endfunction

    // local-bus model: each read returns its per-address read count and the address
    int            lb_delay = 3;
    int            rdcnt[256];
    int            wr_count = 0;
    logic [31:0]   last_wdata = '0;
    logic [15:0]   last_waddr = '0;
    bit            m_busy = 0;
    int            m_cnt = 0;
    logic [AW-1:0] m_addr = '0;

    always @(negedge clk) begin
        if (lb_ack) begin
            lb_ack = 1'b0;
        end else if (lb_req) begin
            if (!m_busy) begin
                m_busy = 1;
                m_cnt  = lb_delay;
                m_addr = lb_addr;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
            if (m_busy && m_cnt == 0) begin
                check(lb_addr == m_addr, "R11", "local address held", lb_addr, m_addr);
                if (lb_we) begin
                    wr_count++;
                    last_wdata = lb_wdata;
                    last_waddr = lb_addr;
                end else begin
                    rdcnt[lb_addr[7:0]]++;
                    lb_rdata = rd_word(rdcnt[lb_addr[7:0]], lb_addr);
                end
                lb_ack = 1'b1;
                m_busy = 0;
            end
        end
    end

    // scoreboard
    typedef struct {
        bit          retry;
        logic [31:0] data;
        bit          use_data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always @(negedge clk) begin
        exp_t e;
        if (!rst && (rsp_done || rsp_retry)) begin
            n_rsp++;
            if (sb.size() == 0) begin
                check(0, "R2", "unexpected response", {30'b0, rsp_done, rsp_retry}, 32'h0);
            end else begin
                e = sb.pop_front();
                check(rsp_retry == e.retry && rsp_done == !e.retry, e.tag, "response kind",
                      {30'b0, rsp_done, rsp_retry}, e.retry ? 32'h1 : 32'h2);
                if (e.use_data && rsp_done)
                    check(rsp_rdata == e.data, e.tag, "read data", rsp_rdata, e.data);
            end
        end
    end

    task automatic xfer(input logic [ID_W-1:0] id, input bit wr, input logic [15:0] addr,
                        input logic [31:0] wdata, input bit exp_retry,
                        input logic [31:0] exp_data, input string tag, output int lat);
        exp_t e;
        int base;
        e.retry = exp_retry; e.data = exp_data; e.use_data = !wr && !exp_retry; e.tag = tag;
        sb.push_back(e);
        base = n_rsp;
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_id = id; req_addr = addr; req_wdata = wdata;
        lat = 0;
        while (n_rsp == base && lat < 1000) begin
            @(negedge clk); #1;
            lat++;
        end
        req_valid = 1'b0;
        if (n_rsp == base) check(0, tag, "no response", 32'h0, 32'h1);
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R1", "watchdog expired", 32'h1, 32'h0);
        summary();
        $finish;
    end

    initial begin
        int lat;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!rsp_done && !rsp_retry && !lb_req, "R1", "reset outputs idle",
              {29'b0, rsp_done, rsp_retry, lb_req}, 32'h0);

        // R2: fast local bus, direct completion
        lb_delay = 3;
        xfer(3'd1, 0, 16'h0010, '0, 0, rd_word(1, 16'h0010), "R2", lat);

        // R10: write elsewhere with idle local bus is posted
        xfer(3'd2, 1, 16'h0020, 32'hCAFE0020, 0, '0, "R10", lat);
        idle(10);
        check(wr_count == 1 && last_wdata == 32'hCAFE0020 && last_waddr == 16'h0020,
              "R10", "posted write reached local bus", last_wdata, 32'hCAFE0020);

        // R3: slow read is deferred inside the window
        lb_delay = 40;
        xfer(3'd1, 0, 16'h0030, '0, 1, '0, "R3", lat);
        check(lat <= LAT, "R3", "retry latency", lat, LAT);

        // R5: owner returns before data arrives
        xfer(3'd1, 0, 16'h0030, '0, 1, '0, "R5", lat);

        // R6: other requester, other address
        lb_delay = 3;
        xfer(3'd2, 0, 16'h0030, '0, 1, '0, "R6", lat);
        xfer(3'd1, 0, 16'h0040, '0, 1, '0, "R6", lat);
        check(rdcnt[8'h40] == 0, "R6", "no local read for refused address", rdcnt[8'h40], 0);

        // R10: write to held address, write while local bus busy
        xfer(3'd3, 1, 16'h0030, 32'h11110030, 1, '0, "R10", lat);
        xfer(3'd3, 1, 16'h0050, 32'h22220050, 1, '0, "R10", lat);
        check(wr_count == 1, "R10", "refused writes not performed", wr_count, 1);

        // R7: non-prefetchable word held far beyond the discard time
        idle(150);
        xfer(3'd3, 0, 16'h0044, '0, 1, '0, "R6", lat);
        xfer(3'd3, 1, 16'h0050, 32'h22220050, 0, '0, "R10", lat);
        idle(10);
        check(wr_count == 2 && last_wdata == 32'h22220050, "R10", "later write performed",
              last_wdata, 32'h22220050);

        // R4 and R7: owner collects the single fetch
        xfer(3'd1, 0, 16'h0030, '0, 0, rd_word(1, 16'h0030), "R4", lat);
        check(rdcnt[8'h30] == 1, "R4", "single local read", rdcnt[8'h30], 1);

        // R8: prefetchable word times out
        lb_delay = 40;
        xfer(3'd2, 0, 16'h8070, '0, 1, '0, "R8", lat);
        idle(150);
        lb_delay = 3;
        xfer(3'd4, 0, 16'h0060, '0, 0, rd_word(1, 16'h0060), "R8", lat);
        check(rdcnt[8'h70] == 1, "R8", "dropped address read once", rdcnt[8'h70], 1);

        // R9: refetch of dropped address is pinned
        lb_delay = 40;
        xfer(3'd2, 0, 16'h8070, '0, 1, '0, "R9", lat);
        idle(150);
        xfer(3'd2, 0, 16'h8070, '0, 0, rd_word(2, 16'h8070), "R9", lat);
        check(rdcnt[8'h70] == 2, "R9", "pinned fetch read once more", rdcnt[8'h70], 2);

        idle(5);
        check(sb.size() == 0, "R2", "all expected responses seen", sb.size(), 0);
        summary();
        $finish;
    end

endmodule